// File: doc/BRIEF.md
# Buffered Two-by-Two Self-Routing Switch Node

This block is a single two-input, two-output switching element for an on-chip network whose traffic consists of short messages. Each input has a buffer sized to hold one whole message. A message is captured into its buffer in full before any of it moves on. The node then reads one configurable bit of the message's first word, and that bit selects the output the message leaves on.

The switch has two settings. In the straight setting, input 0 feeds output 0 and input 1 feeds output 1. In the swapped setting, each input feeds the other output. A held message is launched only when two conditions are met. First, the buffer of the next stage on the chosen output must report that it is empty. Second, if the switch is already carrying a message, it must already be in the setting the new message needs. Once a message is launched, the setting stays fixed until the last word of every active transfer has gone. The node reports the emptiness of its own two buffers so that an upstream stage can apply the same rule to it.

When both inputs can go in the same cycle and want different outputs, they need the same switch setting and both are launched together. When both want the same output, one of them is granted.

Top module: `swn_node`

## Requirements
- R1: After reset both `in_ready` bits are 1, both `buf_empty` bits are 1 and both `out_valid` bits are 0.
- R2: An input buffer takes the first word of a message only while it is empty. Once the final word is stored, that input's `in_ready` is 0 and its `buf_empty` is 0 until the last word has left on an output.
- R3: A message is closed when its final word arrives with `in_last` = 1, or when its DEPTH-th word arrives, whichever comes first. A closed message leaves with `out_last` = 1 on its final word only.
- R4: Bit ADDR_BIT of the first word selects the output: 0 means output 0 and 1 means output 1. The words leave unchanged and in arrival order, and nothing appears on the other output.
- R5: Nothing is forwarded while a message is still arriving. With the downstream buffer free and the switch idle, the first word is offered on the output two cycles after the cycle in which the final word is accepted.
- R6: A message starts only while `out_empty` of its chosen output is 1. If `out_empty` goes from 0 to 1 while a message is held, the first word is offered in the following cycle.
- R7: When both inputs hold messages for different outputs and both become able to go in the same cycle, both start in that cycle.
- R8: When both inputs contend for the same output, input 0 wins the first contention after reset. After each contention, the input that lost it wins the next one. The loser is sent after the winner's last word.
- R9: While `out_valid` is 1 and `out_ready` is 0, that output keeps `out_valid` high and its data and last flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Word offered on each input |
| in_data | input | 2 x W | Input words, one per input |
| in_last | input | 2 | Final word of a message on each input |
| in_ready | output | 2 | Input buffer can take a word |
| buf_empty | output | 2 | Input buffer holds no message, for the upstream stage |
| out_valid | output | 2 | Word offered on each output |
| out_data | output | 2 x W | Output words, one per output |
| out_last | output | 2 | Final word of a message on each output |
| out_ready | input | 2 | Next stage takes the word on each output |
| out_empty | input | 2 | Next stage's input buffer is empty |

## Verification
The bench builds the node with 8-bit words, a buffer depth of 4 and the routing bit at position 5. With this shallow depth, the length cap is reached using short stimulus, and a message that overruns the cap is seen to split into two messages. Because the routing bit is not bit 0, the bench also confirms that the node reads the configured bit position rather than a fixed one. Holding both `out_empty` inputs low while the two buffers fill lets the bench release both inputs in the same cycle. From there it exercises joint launch and round-robin contention, and measures exact start cycles.

// File: rtl/swn_pkg.sv
// Shared types for the buffered switch node.
// Assumes: nothing beyond IEEE 1800-2017.
package swn_pkg;

    // Life cycle of one input message buffer.
    typedef enum logic [1:0] {
        BUF_EMPTY = 2'd0,   // no message, accepting a first word
        BUF_FILL  = 2'd1,   // message partly received
        BUF_HELD  = 2'd2,   // whole message stored, waiting for a grant
        BUF_SEND  = 2'd3    // message streaming out through the switch
    } buf_state_e;

endpackage

// File: rtl/swn_msg_buffer.sv
// One whole-message input buffer.
// Stores a message of up to DEPTH words. The message is closed by
// in_last, or by the DEPTH-th word. The buffer shows the routing bit of the
// first word, and it streams the message out after a start pulse.
// Assumes: DEPTH >= 2; start is only pulsed while held is 1.
module swn_msg_buffer
    import swn_pkg::*;
#(
    parameter int W        = 8,
    parameter int DEPTH    = 8,
    parameter int ADDR_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    output logic         in_ready,
    output logic         held,
    output logic         empty,
    output logic         dest,
    input  logic         start,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         rd_last,
    input  logic         rd_ready
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_IDX = CW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    buf_state_e    st;
    logic [CW-1:0] wr_cnt;
    logic [CW-1:0] rd_ptr;
    logic          accept;
    logic          closing;

    // Decode the handshake and the message-closing condition.
    always_comb begin
        in_ready = (st == BUF_EMPTY) || (st == BUF_FILL);
        accept   = in_valid && in_ready;
        closing  = accept && (in_last || (wr_cnt == CAP_IDX));
        held     = (st == BUF_HELD);
        empty    = (st == BUF_EMPTY);
        dest     = mem[0][ADDR_BIT];
        rd_valid = (st == BUF_SEND);
        rd_data  = mem[rd_ptr[PW-1:0]];
        rd_last  = (rd_ptr == wr_cnt - 1'b1);
    end

    // Word storage; needs no reset because the state gates every read.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_cnt[PW-1:0]] <= in_data;
    end

    // Buffer state machine and its pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= BUF_EMPTY;
            wr_cnt <= '0;
            rd_ptr <= '0;
        end else begin
            if (accept) wr_cnt <= wr_cnt + 1'b1;
            case (st)
                BUF_EMPTY, BUF_FILL: begin
                    if (closing)     st <= BUF_HELD;
                    else if (accept) st <= BUF_FILL;
                end
                BUF_HELD: begin
                    if (start) begin
                        st     <= BUF_SEND;
                        rd_ptr <= '0;
                    end
                end
                BUF_SEND: begin
                    if (rd_ready) begin
                        if (rd_last) begin
                            st     <= BUF_EMPTY;
                            wr_cnt <= '0;
                        end else begin
                            rd_ptr <= rd_ptr + 1'b1;
                        end
                    end
                end
                default: st <= BUF_EMPTY;
            endcase
        end
    end

endmodule

// File: rtl/swn_route_arbiter.sv
// Launch control for the two buffered inputs.
// Decides which held messages may start, and owns the switch setting
// (0 straight, 1 swapped) and the per-input active flags.
// Assumes: done[i] is only high while active[i] is high.
module swn_route_arbiter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] held,
    input  logic [1:0] dest,
    input  logic [1:0] out_empty,
    input  logic [1:0] done,
    output logic [1:0] grant,
    output logic [1:0] active,
    output logic       sw_state
);
    logic [1:0] need_st;
    logic [1:0] eligible;
    logic       contest;
    logic       prio;

    // Setting each input needs, and whether it could start alone.
    for (genvar i = 0; i < 2; i++) begin : g_elig
        always_comb begin
            need_st[i]  = dest[i] ^ 1'(i);
            eligible[i] = held[i] && out_empty[dest[i]] &&
                          (!(|active) || (need_st[i] == sw_state));
        end
    end

    // Resolve contention for one output with the round-robin bit.
    always_comb begin
        contest  = eligible[0] && eligible[1] && (dest[0] == dest[1]);
        grant[0] = eligible[0] && (!contest || !prio);
        grant[1] = eligible[1] && (!contest ||  prio);
    end

    // Track active transfers, the held switch setting and fairness.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 2'b00;
            sw_state <= 1'b0;
            prio     <= 1'b0;
        end else begin
            active <= (active & ~done) | grant;
            if (!(|active) && (|grant))
                sw_state <= grant[0] ? need_st[0] : need_st[1];
            if (contest)
                prio <= grant[0];
        end
    end

endmodule

// File: rtl/swn_crossbar.sv
// Two-by-two data path steered by the switch setting.
// Routes active input streams to outputs and returns the ready signals.
// Assumes: the setting is constant while any transfer is active.
module swn_crossbar #(
    parameter int W = 8
) (
    input  logic [1:0]        rd_valid,
    input  logic [1:0][W-1:0] rd_data,
    input  logic [1:0]        rd_last,
    input  logic [1:0]        active,
    input  logic              sw_state,
    input  logic [1:0]        out_ready,
    output logic [1:0]        out_valid,
    output logic [1:0][W-1:0] out_data,
    output logic [1:0]        out_last,
    output logic [1:0]        rd_ready
);
    for (genvar o = 0; o < 2; o++) begin : g_port
        logic src;
        // Select which input drives output o, and return that input's ready.
        always_comb begin
            src          = 1'(o) ^ sw_state;
            out_valid[o] = active[src] && rd_valid[src];
            out_data[o]  = rd_data[src];
            out_last[o]  = rd_last[src];
            rd_ready[o]  = active[o] && out_ready[1'(o) ^ sw_state];
        end
    end

endmodule

// File: rtl/swn_node.sv
// Buffered two-by-two self-routing switch node.
// Each input stores one whole message. Bit ADDR_BIT of the first word picks
// the output. A message starts only when the next stage is empty and the
// switch setting agrees with any transfer already running.
// Assumes: out_empty reflects the next stage's input buffer.
module swn_node #(
    parameter int W        = 8,
    parameter int DEPTH    = 8,
    parameter int ADDR_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        in_valid,
    input  logic [1:0][W-1:0] in_data,
    input  logic [1:0]        in_last,
    output logic [1:0]        in_ready,
    output logic [1:0]        buf_empty,
    output logic [1:0]        out_valid,
    output logic [1:0][W-1:0] out_data,
    output logic [1:0]        out_last,
    input  logic [1:0]        out_ready,
    input  logic [1:0]        out_empty
);
    logic [1:0]        held;
    logic [1:0]        dest;
    logic [1:0]        grant;
    logic [1:0]        active;
    logic              sw_state;
    logic [1:0]        rd_valid;
    logic [1:0][W-1:0] rd_data;
    logic [1:0]        rd_last;
    logic [1:0]        rd_ready;
    logic [1:0]        done;

    for (genvar i = 0; i < 2; i++) begin : g_in
        swn_msg_buffer #(.W(W), .DEPTH(DEPTH), .ADDR_BIT(ADDR_BIT)) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[i]),
            .in_data  (in_data[i]),
            .in_last  (in_last[i]),
            .in_ready (in_ready[i]),
            .held     (held[i]),
            .empty    (buf_empty[i]),
            .dest     (dest[i]),
            .start    (grant[i]),
            .rd_valid (rd_valid[i]),
            .rd_data  (rd_data[i]),
            .rd_last  (rd_last[i]),
            .rd_ready (rd_ready[i])
        );
        // A transfer ends on the handshake of its final word.
        always_comb done[i] = rd_valid[i] && rd_ready[i] && rd_last[i];
    end

    swn_route_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .held      (held),
        .dest      (dest),
        .out_empty (out_empty),
        .done      (done),
        .grant     (grant),
        .active    (active),
        .sw_state  (sw_state)
    );

    swn_crossbar #(.W(W)) u_xbar (
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_last   (rd_last),
        .active    (active),
        .sw_state  (sw_state),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .rd_ready  (rd_ready)
    );

endmodule

// File: rtl/swn_node_checker.sv
// Port-level properties of the switch node, bound to every instance.
module swn_node_checker #(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        in_valid,
    input logic [1:0]        in_last,
    input logic [1:0]        in_ready,
    input logic [1:0]        buf_empty,
    input logic [1:0]        out_valid,
    input logic [1:0][W-1:0] out_data,
    input logic [1:0]        out_last,
    input logic [1:0]        out_ready,
    input logic [1:0]        out_empty
);
    AST_STALL_HOLDS_0: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] && !out_ready[0] |=> out_valid[0] && $stable(out_data[0]) && $stable(out_last[0])); // R9
    AST_STALL_HOLDS_1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[1] && !out_ready[1] |=> out_valid[1] && $stable(out_data[1]) && $stable(out_last[1])); // R9
    AST_START_NEEDS_ROOM_0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid[0]) |-> $past(out_empty[0])); // R6
    AST_START_NEEDS_ROOM_1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid[1]) |-> $past(out_empty[1])); // R6
    AST_HELD_BLOCKS_IN_0: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[0] && in_ready[0] && in_last[0] |=> !in_ready[0] && !buf_empty[0]); // R2
    AST_HELD_BLOCKS_IN_1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[1] && in_ready[1] && in_last[1] |=> !in_ready[1] && !buf_empty[1]); // R2
endmodule

bind swn_node swn_node_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .buf_empty (buf_empty),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready),
    .out_empty (out_empty)
);

// File: tb/swn_node_test.sv
`timescale 1ns/1ps
module swn_node_test;
    localparam int W = 8, DEPTH = 4, ABIT = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0]        in_valid, in_last, out_ready, out_empty;
    logic [1:0][W-1:0] in_data;
    logic [1:0]        in_ready, buf_empty, out_valid, out_last;
    logic [1:0][W-1:0] out_data;

    int cyc = 0;
    int checks = 0, fails = 0;
    bit finished = 0;

    logic [W-1:0] rec_data [2][256];
    logic         rec_last [2][256];
    int           rec_n [2];
    int           start_cyc [2];
    logic [1:0]   pv;
    int           last_acc [2];

    swn_node #(.W(W), .DEPTH(DEPTH), .ADDR_BIT(ABIT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .buf_empty(buf_empty),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .out_empty(out_empty));

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor: records words and message start cycles away from the edge.
    initial begin
        rec_n[0] = 0; rec_n[1] = 0; pv = 2'b00;
        start_cyc[0] = -1; start_cyc[1] = -1;
        forever begin
            @(negedge clk);
            for (int o = 0; o < 2; o++) begin
                if (out_valid[o] && !pv[o]) start_cyc[o] = cyc;
                pv[o] = out_valid[o];
                if (out_valid[o] && out_ready[o]) begin
                    rec_data[o][rec_n[o]] = out_data[o];
                    rec_last[o][rec_n[o]] = out_last[o];
                    rec_n[o]++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mkw(input bit src, input bit dst, input int idx);
        logic [W-1:0] w;
        w = '0;
        w[7] = src; w[ABIT] = dst; w[4:0] = 5'(idx);
        return w;
    endfunction

    task automatic send_word(input int p, input logic [W-1:0] d, input logic l);
        @(negedge clk);
        in_valid[p] = 1'b1; in_data[p] = d; in_last[p] = l;
        while (!in_ready[p]) @(negedge clk);
        last_acc[p] = cyc;
        @(posedge clk);
    endtask

    task automatic send_msg(input int p, input bit src, input bit dst, input int len, input int base, input bit with_last);
        for (int k = 0; k < len; k++)
            send_word(p, mkw(src, dst, base + k), with_last && (k == len - 1));
        @(negedge clk);
        in_valid[p] = 1'b0; in_last[p] = 1'b0;
    endtask

    task automatic set_ds(input logic [1:0] rdy, input logic [1:0] emp);
        @(posedge clk); #2;
        out_ready = rdy; out_empty = emp;
    endtask

    task automatic wait_words(input int o, input int n);
        while (rec_n[o] < n) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(buf_empty == 2'b11 && out_valid == 2'b00)) @(negedge clk);
    endtask

    task automatic expect_msg(input int o, input int at, input bit src, input bit dst, input int len, input int base, input string req);
        for (int k = 0; k < len; k++) begin
            chk(rec_data[o][at + k] == mkw(src, dst, base + k), req, "word", int'(rec_data[o][at + k]), int'(mkw(src, dst, base + k)));
            chk(rec_last[o][at + k] == (k == len - 1), req, "last flag", int'(rec_last[o][at + k]), int'(k == len - 1));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(in_ready == 2'b11, "R1", "in_ready", int'(in_ready), 3);
        chk(buf_empty == 2'b11, "R1", "buf_empty", int'(buf_empty), 3);
        chk(out_valid == 2'b00, "R1", "out_valid", int'(out_valid), 0);
    endtask

    task automatic t_single(input int p, input bit dst, input int len, input int base);
        int n0, n1, nd;
        n0 = rec_n[0]; n1 = rec_n[1];
        nd = dst ? n1 : n0;
        send_msg(p, 1'(p), dst, len, base, 1'b1);
        wait_words(int'(dst), nd + len);
        chk(start_cyc[dst] == last_acc[p] + 2, "R5", "start cycle", start_cyc[dst], last_acc[p] + 2);
        expect_msg(int'(dst), nd, 1'(p), dst, len, base, "R4");
        wait_idle();
        chk(rec_n[!dst] == (dst ? n0 : n1), "R4", "other output words", rec_n[!dst], dst ? n0 : n1);
        chk(in_ready[p] && buf_empty[p], "R2", "ready after drain", int'(in_ready[p]), 1);
    endtask

    task automatic t_blocked();
        int n0, rel;
        n0 = rec_n[0];
        set_ds(2'b11, 2'b00);
        send_msg(0, 1'b0, 1'b0, 2, 8, 1'b1);
        repeat (6) @(negedge clk);
        chk(out_valid == 2'b00, "R6", "valid while next stage busy", int'(out_valid), 0);
        chk(!in_ready[0], "R2", "in_ready while held", int'(in_ready[0]), 0);
        chk(!buf_empty[0], "R2", "buf_empty while held", int'(buf_empty[0]), 0);
        set_ds(2'b11, 2'b11);
        rel = cyc;
        wait_words(0, n0 + 2);
        chk(start_cyc[0] == rel + 1, "R6", "start after release", start_cyc[0], rel + 1);
        expect_msg(0, n0, 1'b0, 1'b0, 2, 8, "R6");
        wait_idle();
    endtask

    task automatic t_cap();
        int n0, n1;
        n0 = rec_n[0]; n1 = rec_n[1];
        send_msg(0, 1'b0, 1'b1, DEPTH, 12, 1'b0);
        send_msg(0, 1'b0, 1'b0, 1, 20, 1'b1);
        wait_words(1, n1 + DEPTH);
        wait_words(0, n0 + 1);
        expect_msg(1, n1, 1'b0, 1'b1, DEPTH, 12, "R3");
        expect_msg(0, n0, 1'b0, 1'b0, 1, 20, "R3");
        wait_idle();
    endtask

    task automatic t_both();
        int n0, n1;
        n0 = rec_n[0]; n1 = rec_n[1];
        set_ds(2'b11, 2'b00);
        fork
            send_msg(0, 1'b0, 1'b0, 2, 3, 1'b1);
            send_msg(1, 1'b1, 1'b1, 3, 6, 1'b1);
        join
        repeat (2) @(negedge clk);
        set_ds(2'b11, 2'b11);
        wait_words(0, n0 + 2);
        wait_words(1, n1 + 3);
        chk(start_cyc[0] == start_cyc[1], "R7", "joint start", start_cyc[0], start_cyc[1]);
        expect_msg(0, n0, 1'b0, 1'b0, 2, 3, "R7");
        expect_msg(1, n1, 1'b1, 1'b1, 3, 6, "R7");
        wait_idle();
    endtask

    task automatic t_contend(input bit exp_first);
        int n0;
        n0 = rec_n[0];
        set_ds(2'b11, 2'b00);
        fork
            send_msg(0, 1'b0, 1'b0, 2, 1, 1'b1);
            send_msg(1, 1'b1, 1'b0, 2, 4, 1'b1);
        join
        repeat (2) @(negedge clk);
        set_ds(2'b11, 2'b11);
        wait_words(0, n0 + 4);
        chk(rec_data[0][n0][7] == exp_first, "R8", "first winner", int'(rec_data[0][n0][7]), int'(exp_first));
        expect_msg(0, n0, exp_first, 1'b0, 2, exp_first ? 4 : 1, "R8");
        expect_msg(0, n0 + 2, !exp_first, 1'b0, 2, exp_first ? 1 : 4, "R8");
        wait_idle();
    endtask

    task automatic t_backpressure();
        int n1;
        n1 = rec_n[1];
        set_ds(2'b01, 2'b11);
        fork
            send_msg(0, 1'b0, 1'b1, 4, 9, 1'b1);
            for (int i = 0; rec_n[1] < n1 + 4; i++) begin
                @(posedge clk); #2;
                out_ready[1] = (i % 3 != 2) && (i > 6);
            end
        join
        out_ready[1] = 1'b1;
        expect_msg(1, n1, 1'b0, 1'b1, 4, 9, "R9");
        wait_idle();
    endtask

    initial begin
        rst_n = 1'b0; in_valid = '0; in_last = '0; in_data = '0;
        out_ready = 2'b11; out_empty = 2'b11;
        last_acc[0] = 0; last_acc[1] = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_single(0, 1'b1, 3, 1);
        t_single(1, 1'b0, 2, 5);
        t_blocked();
        t_cap();
        t_both();
        t_contend(1'b0);
        t_contend(1'b1);
        t_backpressure();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule